// File: doc/BRIEF.md
# Multi-Size Software-Loaded TLB

This block is a fully associative address-translation cache with a parameterised number of entries (32 by default). The hardware never fills it on its own. Software first stages a virtual-side word and a physical-side word in two registers. It then writes a load strobe, and both words are copied into the entry that the replacement pointer names. Every entry carries its own page-size code, so one table can hold 4 KB, 64 KB, 1 MB and 16 MB mappings side by side. Each entry compares only the address bits that its own page size covers.

A lookup port takes a 32-bit virtual address. One clock later it returns a hit flag, the translated physical address and four attribute bits. A lock register splits the table in two. Entries below a base index are never chosen by the advancing replacement pointer. A global flush invalidates every entry whose keep bit is clear. A translation-enable bit selects between translating and passing addresses straight through.

Top module: `multisize_tlb`

## Requirements
- R1: The register port decodes byte offsets on `reg_addr`:
  - 0x00: control, with bit 0 as translation enable.
  - 0x04: lock.
  - 0x08: virtual-side staging word. Tag in bits 31:12, keep in bit 3, valid in bit 2, size code in bits 1:0.
  - 0x0C: physical-side staging word. Frame in bits 31:12, byte-order flag in bit 9, element width in bits 8:7, mixed-width select in bit 6.
  - 0x10: load strobe.
  - 0x60: flush strobe.

  Reading offsets 0x00 through 0x0C returns the stored word. For 0x00 only bit 0 is stored. For 0x04 only the base and victim fields are stored.
- R2: Writing 0x10 with bit 0 set copies both staging words into the entry indexed by the victim field. Writing it with bit 0 clear changes nothing.
- R3: The size code selects which virtual bits an entry compares: 0 compares 31:20, 1 compares 31:16, 2 compares 31:12, and 3 compares 31:24. Only entries whose valid bit is set can match.
- R4: On a hit, `lu_paddr` takes the entry's frame bits for the compared bit range and the lookup address for all lower bits. `lu_attr` is {byte-order, element width[1:0], mixed}.
- R5: With translation enabled and no matching entry, `lu_hit` is 0 and `lu_paddr` is 0.
- R6: With translation disabled, `lu_hit` is 1, `lu_paddr` equals the lookup address, and `lu_attr` is 0.
- R7: The lock register holds the locked base in bits 4:0 and the victim in bits 12:8, and a write sets both fields directly. After each load the victim moves up by one. From the last entry it wraps to the locked base.
- R8: Writing 0x60 with bit 0 set clears the valid bit of every entry whose keep bit is 0. Entries with the keep bit set are left unchanged. Writing 0x60 with bit 0 clear has no effect.
- R9: When several entries match, the lowest-indexed entry supplies the translation.
- R10: Lookup results are registered. The outputs in a cycle reflect the address and the table contents of the previous cycle, so a load in the same cycle as a lookup is seen only by the next lookup.
- R11: After reset, translation is disabled, every entry is invalid, the lock fields are 0, and all lookup outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` (combinational) |
| lu_vaddr | input | 32 | Lookup virtual address |
| lu_hit | output | 1 | Registered hit flag |
| lu_paddr | output | 32 | Registered physical address |
| lu_attr | output | 4 | Registered page attributes |

## Verification
A lookup and a table update can fall in the same cycle. The update is either a load that rewrites the entry the lookup is hitting, or a flush of that entry. The bench provokes this by driving the lookup address and the load strobe on the same falling edge, with the victim pointing at the entry that maps the address. It expects the old frame on the next sample and the new frame one lookup later. Randomised phases interleave loads, flushes and lookups against a bench model. That model holds the table as raw staged words and recomputes every result with its own shift-based masks.

// File: rtl/tlb_pkg.sv
package tlb_pkg;

  localparam int VA_W   = 32;
  localparam int PG_SH  = 12;
  localparam int TAG_W  = VA_W - PG_SH;
  localparam int ATTR_W = 4;

  typedef enum logic [1:0] {
    PG_SECTION = 2'd0,
    PG_LARGE   = 2'd1,
    PG_SMALL   = 2'd2,
    PG_SUPER   = 2'd3
  } pg_size_e;

  typedef struct packed {
    logic              valid;
    logic              keep;
    pg_size_e          size;
    logic [TAG_W-1:0]  vtag;
    logic [TAG_W-1:0]  pfn;
    logic [ATTR_W-1:0] attr;
  } tlb_entry_t;

  // Tag bits that take part in the compare for each page size.
  function automatic logic [TAG_W-1:0] tag_mask(input pg_size_e s);
    logic [TAG_W-1:0] m;
    case (s)
      PG_SECTION: m = 20'hFFF00;
      PG_LARGE:   m = 20'hFFFF0;
      PG_SMALL:   m = 20'hFFFFF;
      default:    m = 20'hFF000;
    endcase
    return m;
  endfunction

  function automatic logic tag_match(input tlb_entry_t e, input logic [TAG_W-1:0] vpn);
    return e.valid && (((e.vtag ^ vpn) & tag_mask(e.size)) == '0);
  endfunction

  function automatic logic [VA_W-1:0] xlate(input tlb_entry_t e, input logic [VA_W-1:0] va);
    logic [TAG_W-1:0] m;
    m = tag_mask(e.size);
    return {(e.pfn & m) | (va[VA_W-1:PG_SH] & ~m), va[PG_SH-1:0]};
  endfunction

  // Build a table entry from the two staged words.
  function automatic tlb_entry_t pack_entry(input logic [31:0] vw, input logic [31:0] pw);
    tlb_entry_t e;
    e.vtag  = vw[31:12];
    e.keep  = vw[3];
    e.valid = vw[2];
    e.size  = pg_size_e'(vw[1:0]);
    e.pfn   = pw[31:12];
    e.attr  = {pw[9], pw[8:7], pw[6]};
    return e;
  endfunction

endpackage

// File: rtl/tlb_regs.sv
module tlb_regs
  import tlb_pkg::*;
#(
  parameter int N    = 32,
  parameter int AW   = 8,
  parameter int IDXW = $clog2(N)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            reg_we,
  input  logic [AW-1:0]   reg_addr,
  input  logic [31:0]     reg_wdata,
  output logic [31:0]     reg_rdata,
  output logic            xl_enable,
  output logic [31:0]     vstage,
  output logic [31:0]     pstage,
  output logic            load_fire,
  output logic            flush_fire,
  output logic [IDXW-1:0] victim,
  output logic [IDXW-1:0] lock_base
);

  localparam logic [AW-1:0] OFF_CTRL  = AW'(8'h00);
  localparam logic [AW-1:0] OFF_LOCK  = AW'(8'h04);
  localparam logic [AW-1:0] OFF_VSTG  = AW'(8'h08);
  localparam logic [AW-1:0] OFF_PSTG  = AW'(8'h0C);
  localparam logic [AW-1:0] OFF_LOAD  = AW'(8'h10);
  localparam logic [AW-1:0] OFF_FLUSH = AW'(8'h60);
  localparam int            VIC_LSB   = 8;
  localparam logic [IDXW-1:0] LAST    = IDXW'(N - 1);

  function automatic logic [IDXW-1:0] step_victim(input logic [IDXW-1:0] v,
                                                  input logic [IDXW-1:0] b);
    return (v == LAST) ? b : v + 1'b1;
  endfunction

  assign load_fire  = reg_we && (reg_addr == OFF_LOAD)  && reg_wdata[0];
  assign flush_fire = reg_we && (reg_addr == OFF_FLUSH) && reg_wdata[0];

  always_ff @(posedge clk) begin
    if (rst) begin
      xl_enable <= 1'b0;
      vstage    <= '0;
      pstage    <= '0;
      victim    <= '0;
      lock_base <= '0;
    end else if (reg_we) begin
      case (reg_addr)
        OFF_CTRL: xl_enable <= reg_wdata[0];
        OFF_LOCK: begin
          lock_base <= reg_wdata[IDXW-1:0];
          victim    <= reg_wdata[VIC_LSB +: IDXW];
        end
        OFF_VSTG: vstage <= reg_wdata;
        OFF_PSTG: pstage <= reg_wdata;
        OFF_LOAD: if (reg_wdata[0]) victim <= step_victim(victim, lock_base);
        default: ;
      endcase
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      OFF_CTRL: reg_rdata[0] = xl_enable;
      OFF_LOCK: begin
        reg_rdata[IDXW-1:0]         = lock_base;
        reg_rdata[VIC_LSB +: IDXW]  = victim;
      end
      OFF_VSTG: reg_rdata = vstage;
      OFF_PSTG: reg_rdata = pstage;
      default:  reg_rdata = '0;
    endcase
  end

endmodule

// File: rtl/tlb_array.sv
module tlb_array
  import tlb_pkg::*;
#(
  parameter int N    = 32,
  parameter int IDXW = $clog2(N)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load_fire,
  input  logic             flush_fire,
  input  logic [IDXW-1:0]  victim,
  input  tlb_entry_t       new_entry,
  input  logic [TAG_W-1:0] look_vpn,
  output tlb_entry_t       ents [N],
  output logic [N-1:0]     hit_vec,
  output logic [N-1:0]     valid_vec,
  output logic [N-1:0]     keep_vec
);

  for (genvar i = 0; i < N; i++) begin : g_ent
    always_ff @(posedge clk) begin
      if (rst) begin
        ents[i] <= '0;
      end else if (load_fire && (victim == IDXW'(i))) begin
        ents[i] <= new_entry;
      end else if (flush_fire && !ents[i].keep) begin
        ents[i].valid <= 1'b0;
      end
    end
    assign hit_vec[i]   = tag_match(ents[i], look_vpn);
    assign valid_vec[i] = ents[i].valid;
    assign keep_vec[i]  = ents[i].keep;
  end

endmodule

// File: rtl/tlb_select.sv
module tlb_select
  import tlb_pkg::*;
#(
  parameter int N    = 32,
  parameter int IDXW = $clog2(N)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              xl_enable,
  input  logic [VA_W-1:0]   va,
  input  logic [N-1:0]      hit_vec,
  input  tlb_entry_t        ents [N],
  output logic              lu_hit,
  output logic [VA_W-1:0]   lu_paddr,
  output logic [ATTR_W-1:0] lu_attr
);

  logic            any_hit;
  logic [IDXW-1:0] win_idx;
  tlb_entry_t      win;

  // Lowest index wins: scan downward so the last assignment is the lowest.
  always_comb begin
    any_hit = 1'b0;
    win_idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (hit_vec[i]) begin
        any_hit = 1'b1;
        win_idx = IDXW'(i);
      end
    end
  end

  assign win = ents[win_idx];

  always_ff @(posedge clk) begin
    if (rst) begin
      lu_hit   <= 1'b0;
      lu_paddr <= '0;
      lu_attr  <= '0;
    end else if (!xl_enable) begin
      lu_hit   <= 1'b1;
      lu_paddr <= va;
      lu_attr  <= '0;
    end else if (any_hit) begin
      lu_hit   <= 1'b1;
      lu_paddr <= xlate(win, va);
      lu_attr  <= win.attr;
    end else begin
      lu_hit   <= 1'b0;
      lu_paddr <= '0;
      lu_attr  <= '0;
    end
  end

endmodule

// File: rtl/multisize_tlb.sv
module multisize_tlb
  import tlb_pkg::*;
#(
  parameter int N    = 32,
  parameter int AW   = 8,
  parameter int IDXW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          reg_we,
  input  logic [AW-1:0] reg_addr,
  input  logic [31:0]   reg_wdata,
  output logic [31:0]   reg_rdata,
  input  logic [31:0]   lu_vaddr,
  output logic          lu_hit,
  output logic [31:0]   lu_paddr,
  output logic [3:0]    lu_attr
);

  logic            xl_enable;
  logic [31:0]     vstage;
  logic [31:0]     pstage;
  logic            load_fire;
  logic            flush_fire;
  logic [IDXW-1:0] victim;
  logic [IDXW-1:0] lock_base;
  tlb_entry_t      ents [N];
  logic [N-1:0]    hit_vec;
  logic [N-1:0]    valid_vec;
  logic [N-1:0]    keep_vec;

  tlb_regs #(.N(N), .AW(AW), .IDXW(IDXW)) u_regs (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .xl_enable(xl_enable),
    .vstage(vstage), .pstage(pstage), .load_fire(load_fire),
    .flush_fire(flush_fire), .victim(victim), .lock_base(lock_base)
  );

  tlb_array #(.N(N), .IDXW(IDXW)) u_array (
    .clk(clk), .rst(rst), .load_fire(load_fire), .flush_fire(flush_fire),
    .victim(victim), .new_entry(pack_entry(vstage, pstage)),
    .look_vpn(lu_vaddr[31:12]), .ents(ents), .hit_vec(hit_vec),
    .valid_vec(valid_vec), .keep_vec(keep_vec)
  );

  tlb_select #(.N(N), .IDXW(IDXW)) u_select (
    .clk(clk), .rst(rst), .xl_enable(xl_enable), .va(lu_vaddr),
    .hit_vec(hit_vec), .ents(ents), .lu_hit(lu_hit),
    .lu_paddr(lu_paddr), .lu_attr(lu_attr)
  );

endmodule

// File: rtl/multisize_tlb_checker.sv
module multisize_tlb_checker #(
  parameter int N    = 32,
  parameter int IDXW = $clog2(N)
) (
  input logic            clk,
  input logic            rst,
  input logic            xl_enable,
  input logic            load_fire,
  input logic            flush_fire,
  input logic [IDXW-1:0] victim,
  input logic [IDXW-1:0] lock_base,
  input logic [N-1:0]    hit_vec,
  input logic [N-1:0]    valid_vec,
  input logic [N-1:0]    keep_vec,
  input logic [31:0]     lu_vaddr,
  input logic            lu_hit,
  input logic [31:0]     lu_paddr
);

  logic armed;
  always_ff @(posedge clk) begin
    if (rst) armed <= 1'b0;
    else     armed <= 1'b1;
  end

  assert_victim_step_R7: assert property (@(posedge clk) disable iff (rst)
    load_fire |=> victim == (($past(victim) == IDXW'(N - 1)) ? $past(lock_base)
                                                           : IDXW'($past(victim) + 1'b1)));

  assert_victim_floor_R7: assert property (@(posedge clk) disable iff (rst)
    (load_fire && victim >= lock_base) |=> victim >= lock_base);

  assert_flush_clears_R8: assert property (@(posedge clk) disable iff (rst)
    flush_fire |=> (valid_vec & ~keep_vec) == '0);

  assert_flush_keeps_R8: assert property (@(posedge clk) disable iff (rst)
    flush_fire |=> (valid_vec & keep_vec) == $past(valid_vec & keep_vec));

  assert_passthrough_R6: assert property (@(posedge clk) disable iff (rst || !armed)
    !$past(xl_enable) |-> (lu_hit && lu_paddr == $past(lu_vaddr)));

  assert_miss_low_R5: assert property (@(posedge clk) disable iff (rst || !armed)
    ($past(xl_enable) && $past(hit_vec) == '0) |-> !lu_hit);

  assert_hit_registered_R10: assert property (@(posedge clk) disable iff (rst || !armed)
    ($past(xl_enable) && $past(hit_vec) != '0) |-> lu_hit);

endmodule

bind multisize_tlb multisize_tlb_checker #(.N(N), .IDXW(IDXW)) u_chk (
  .clk(clk), .rst(rst), .xl_enable(xl_enable), .load_fire(load_fire),
  .flush_fire(flush_fire), .victim(victim), .lock_base(lock_base),
  .hit_vec(hit_vec), .valid_vec(valid_vec), .keep_vec(keep_vec),
  .lu_vaddr(lu_vaddr), .lu_hit(lu_hit), .lu_paddr(lu_paddr)
);

// File: tb/multisize_tlb_bench.sv
module multisize_tlb_bench;

  localparam int CLK_PERIOD = 10;
  localparam int NE = 32;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_we = 1'b0;
  logic [7:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [31:0] lu_vaddr = '0;
  logic        lu_hit;
  logic [31:0] lu_paddr;
  logic [3:0]  lu_attr;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  // bench model: raw staged words per entry
  logic [31:0] m_v [NE];
  logic [31:0] m_p [NE];
  logic [31:0] s_v, s_p;
  int m_vic, m_base;
  bit m_en;

  always #(CLK_PERIOD/2) clk = ~clk;

  multisize_tlb u_multisize_tlb (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .lu_vaddr(lu_vaddr),
    .lu_hit(lu_hit), .lu_paddr(lu_paddr), .lu_attr(lu_attr)
  );

  function automatic int cmp_bits(input logic [1:0] code);
    case (code)
      2'd0: return 12;
      2'd1: return 16;
      2'd2: return 20;
      default: return 8;
    endcase
  endfunction

  function automatic void ref_lookup(input logic [31:0] va, output logic h,
                                     output logic [31:0] pa, output logic [3:0] at);
    h = 0; pa = 0; at = 0;
    if (!m_en) begin h = 1; pa = va; return; end
    for (int i = 0; i < NE; i++) begin
      logic [31:0] hm;
      hm = 32'hFFFF_FFFF << (32 - cmp_bits(m_v[i][1:0]));
      if (m_v[i][2] && (((va ^ m_v[i]) & hm) == 0)) begin
        h  = 1;
        pa = (m_p[i] & hm) | (va & ~hm);
        at = {m_p[i][9], m_p[i][8], m_p[i][7], m_p[i][6]};
        return;
      end
    end
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 0;
    if (a == 8'h00) m_en = d[0];
    if (a == 8'h04) begin m_base = int'(d[4:0]); m_vic = int'(d[12:8]); end
    if (a == 8'h08) s_v = d;
    if (a == 8'h0C) s_p = d;
    if (a == 8'h10 && d[0]) begin
      m_v[m_vic] = s_v; m_p[m_vic] = s_p;
      m_vic = (m_vic == NE - 1) ? m_base : m_vic + 1;
    end
    if (a == 8'h60 && d[0])
      for (int i = 0; i < NE; i++) if (!m_v[i][3]) m_v[i][2] = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic load(input logic [31:0] vw, input logic [31:0] pw);
    wr(8'h08, vw); wr(8'h0C, pw); wr(8'h10, 32'h1);
  endtask

  task automatic look(input logic [31:0] va, input string req);
    logic h; logic [31:0] pa; logic [3:0] at;
    @(negedge clk);
    lu_vaddr = va;
    ref_lookup(va, h, pa, at);
    @(negedge clk);
    check(req, {31'b0, lu_hit}, {31'b0, h});
    if (h) begin
      check(req, lu_paddr, pa);
      check(req, {28'b0, lu_attr}, {28'b0, at});
    end else check(req, lu_paddr, 32'h0);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    void'($urandom(32'h5EED_1234));
    for (int i = 0; i < NE; i++) begin m_v[i] = 0; m_p[i] = 0; end
    s_v = 0; s_p = 0; m_vic = 0; m_base = 0; m_en = 0;
    repeat (3) @(negedge clk);
    rst = 0;

    // R11 reset state
    check("R11 hit", {31'b0, lu_hit}, 32'h0);
    check("R11 paddr", lu_paddr, 32'h0);
    rd(8'h04, d); check("R11 lock", d, 32'h0);
    rd(8'h00, d); check("R11 ctrl", d, 32'h0);

    // R6 passthrough while disabled
    look(32'hDEAD_BEEF, "R6 passthrough");
    check("R6 attr", {28'b0, lu_attr}, 32'h0);

    wr(8'h00, 32'h1);
    rd(8'h00, d); check("R1 ctrl readback", d, 32'h1);
    // R5 empty table misses
    look(32'h1234_5678, "R5 miss empty");

    // R1 R2 R3 R4: one entry of each size
    load(32'h12345_000 | 32'h6, 32'hAAAAA_000 | 32'h2C0); // small, valid
    rd(8'h08, d); check("R1 vstage readback", d, 32'h12345006);
    rd(8'h04, d); check("R7 victim after load", d, 32'h100);
    load(32'h40000_000 | 32'h4, 32'h55500_000 | 32'h200); // section
    load(32'h77770_000 | 32'h5, 32'h11110_000 | 32'h180); // large
    load(32'h9A000_000 | 32'h7, 32'hC3000_000 | 32'h040); // super
    look(32'h1234_5ABC, "R4 small hit");
    look(32'h4009_9123, "R3 section hit");
    look(32'h7777_F00F, "R3 large hit");
    look(32'h9ABC_DEF0, "R3 super hit");
    look(32'h1234_6ABC, "R5 small neighbour miss");
    // R2 load with bit0 clear does nothing
    wr(8'h08, 32'hFEDCB_006); wr(8'h10, 32'h0);
    rd(8'h04, d); check("R2 inert load victim", d, 32'h400);
    look(32'hFEDC_B000, "R2 inert load no entry");

    // R9 priority: entry 4 super covering 0x12xxxxxx with other frame
    load(32'h12000_007, 32'hE0000_000);
    look(32'h1234_5000, "R9 lowest index wins");
    look(32'h12FF_0000, "R9 only super matches");

    // R10 load and lookup in the same cycle on entry 0
    wr(8'h04, 32'h0000_0000);
    wr(8'h08, 32'h12345_006); wr(8'h0C, 32'hBBBBB_000);
    @(negedge clk);
    lu_vaddr = 32'h1234_5010; reg_we = 1; reg_addr = 8'h10; reg_wdata = 32'h1;
    @(negedge clk);
    reg_we = 0;
    check("R10 old frame same cycle", lu_paddr, 32'hAAAAA010);
    m_v[0] = s_v; m_p[0] = s_p; m_vic = 1;
    @(negedge clk);
    check("R10 new frame next cycle", lu_paddr, 32'hBBBBB010);

    // R7 lock base and wrap
    wr(8'h04, 32'h0000_1E1C); // base 28, victim 30
    load(32'h00001_006, 32'h0);
    load(32'h00002_006, 32'h0);
    rd(8'h04, d); check("R7 wrap to base", d, 32'h0000_1C1C);
    load(32'h00003_006, 32'h0);
    rd(8'h04, d); check("R7 step after wrap", d, 32'h0000_1D1C);

    // random phase, R3 R4 R9
    wr(8'h04, 32'h0);
    for (int n = 0; n < 64; n++) begin
      logic [31:0] vw, pw;
      vw = {4'h3, 4'($urandom % 4), 12'($urandom), 12'h0} | (32'($urandom) & 32'hF) | 32'h4;
      if (($urandom % 5) == 0) vw[2] = 1'b0;
      pw = {20'($urandom), 2'b0, 4'($urandom) & 4'hF, 6'b0};
      load(vw, pw);
    end
    for (int n = 0; n < 200; n++) begin
      logic [31:0] va;
      int k;
      k  = int'($urandom % NE);
      va = (($urandom % 4) == 0) ? 32'($urandom) : (m_v[k] & 32'hFFFF_F000) ^ (32'($urandom) & 32'h00FF_FFFF);
      look(va, "R3 R4 random");
    end

    // R8 flush: inert write first, then real flush
    wr(8'h60, 32'h0);
    for (int i = 0; i < 8; i++) look(m_v[i] & 32'hFFFF_F000, "R8 inert flush");
    wr(8'h60, 32'h1);
    for (int i = 0; i < NE; i++) look(m_v[i] & 32'hFFFF_F000, "R8 flush keeps preserved");

    // R6 disable again after loads
    wr(8'h00, 32'h0);
    look(32'h3123_4567, "R6 passthrough after disable");

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule